// File: doc/BRIEF.md
# Reliability-Ordered Key Recovery Search

This block turns a noisy physical fingerprint response into a repeatable key without any stored correction data. On `start` it collects a fixed, odd number of response readings over a valid/ready stream and keeps a per-bit count of ones. Each bit of the working value is then the majority vote of its readings. Every bit takes part; no bit is dropped for being noisy.

The block then offers candidate keys, one at a time, to an external validity checker. An example checker is a known plaintext/ciphertext comparison. The first candidate is the majority value itself. The block then widens the search one flip at a time: every candidate with one flipped bit, then every candidate with two, up to a parameter limit. A table ranks the bits from most to least error-prone, and the candidates within a round follow that ranking. If no candidate in these rounds is accepted, the block walks the rest of the value space without offering any candidate twice. The search ends on the first accepted candidate, which becomes the key, or it ends with a failure once the whole space has been tried.

Back-pressure rules:
- The sample stream transfers on cycles where both `samp_valid` and `samp_ready` are high.
- `samp_ready` is high only while readings are still being collected.
- The candidate stream holds `cand_valid` and `cand_data` steady until `cand_ready` is seen.
- The next candidate is not offered until a `chk_done` pulse has answered the current one.

Top module: `puf_key_search`

## Requirements
- R1: Sampling takes exactly NSAMP readings. A transfer happens on each cycle where `samp_valid` and `samp_ready` are both high. `samp_ready` is high only during collection. Bit i of the working value is 1 when more than NSAMP/2 of the readings had bit i set.
- R2: The first candidate offered after sampling is the working value with no bit flipped.
- R3: Flip masks are formed in rank space. A rank mask m flips bit `rank_tbl` entry r for each set bit r of m. Round d offers every mask with exactly d set bits, in increasing numeric value of m. Round d runs for d = 1 up to MAXD, and round d completes before round d+1 starts.
- R4: Entry r of `rank_tbl` occupies bits [r*IDXW +: IDXW] and holds the bit index with the r-th highest error rate. Entry 0 is the most error-prone bit.
- R5: After the last broadening round, the block offers every rank mask with more than MAXD set bits, in increasing numeric order. No candidate is offered twice, and 2^W candidates are offered at most.
- R6: `cand_valid` and `cand_data` stay stable until `cand_ready` is seen. Only one candidate is outstanding at a time. A `chk_done` pulse that arrives while no candidate is outstanding has no effect.
- R7: When a `chk_done` pulse arrives with `chk_match` high, the block raises `done` and `success`. `key` then holds the accepted candidate, and `cand_count` holds the number of candidates transferred.
- R8: When every candidate has been rejected, the block raises `done` and `failure`, and `cand_count` equals 2^W.
- R9: After reset, all outputs are low or zero. `start` is accepted only in idle or done; while a run is in progress it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new recovery run |
| samp_valid | input | 1 | Response reading available |
| samp_ready | output | 1 | Block accepts a reading |
| samp_data | input | W | Response reading |
| rank_tbl | input | W*IDXW | Bit indices ordered from most to least error-prone |
| cand_valid | output | 1 | Candidate offered to checker |
| cand_ready | input | 1 | Checker takes the candidate |
| cand_data | output | W | Candidate key |
| chk_done | input | 1 | Checker verdict pulse |
| chk_match | input | 1 | Verdict: candidate accepted |
| done | output | 1 | Run finished |
| success | output | 1 | A candidate was accepted |
| failure | output | 1 | Search space used up |
| key | output | W | Accepted key |
| cand_count | output | W+1 | Candidates transferred this run |

## Verification
The assertions assume the following about the environment:
- The checker sends at most one `chk_done` pulse per transferred candidate, and only after the transfer.
- `rank_tbl` is a permutation and stays constant during a run.
- NSAMP is odd.

The stimulus keeps within these limits. The bench checker answers each transfer once, after a fixed delay. It uses a fixed permuted table. Its only deliberately stray pulse arrives while a candidate is still waiting for `cand_ready`, which is the case R6 says is ignored. Readings arrive with gaps, and `cand_ready` is withheld on a repeating pattern, so both back-pressure paths are exercised.

// File: rtl/puf_search_pkg.sv
package puf_search_pkg;
  typedef enum logic [2:0] {
    T_IDLE, T_SAMPLE, T_LAUNCH, T_SEEK, T_OFFER, T_WAIT, T_DONE
  } ctl_state_t;

  typedef enum logic [2:0] {
    G_IDLE, G_BROAD, G_SKIP, G_EXH, G_EMPTY
  } gen_state_t;
endpackage

// File: rtl/puf_majority.sv
module puf_majority #(
  parameter int W     = 16,
  parameter int NSAMP = 351
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         take,
  input  logic [W-1:0] data,
  output logic [W-1:0] maj,
  output logic         full
);
  localparam int CW   = $clog2(NSAMP + 1);
  localparam int HALF = NSAMP / 2;

  logic [CW-1:0] scnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) scnt <= '0;
    else if (take)     scnt <= scnt + CW'(1);
  end

  assign full = (scnt == CW'(NSAMP));

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] ones;
    always_ff @(posedge clk) begin
      if (!rst_n || clr)     ones <= '0;
      else if (take && data[i]) ones <= ones + CW'(1);
    end
    assign maj[i] = (ones > CW'(HALF));
  end

  assert_take_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !full);
  assert_sample_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    scnt <= CW'(NSAMP));
endmodule

// File: rtl/puf_rank_map.sv
module puf_rank_map #(
  parameter int W    = 16,
  parameter int IDXW = 4
) (
  input  logic [W-1:0]      rmask,
  input  logic [W*IDXW-1:0] tbl,
  output logic [W-1:0]      bmask
);
  always_comb begin
    bmask = '0;
    for (int r = 0; r < W; r++) begin
      if (rmask[r]) bmask[tbl[r*IDXW +: IDXW]] = 1'b1;
    end
  end
endmodule

// File: rtl/puf_mask_gen.sv
module puf_mask_gen
  import puf_search_pkg::*;
#(
  parameter int W    = 16,
  parameter int MAXD = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         adv,
  output logic         rdy,
  output logic         empty,
  output logic [W-1:0] rmask
);
  localparam int DMAX = (MAXD < W) ? MAXD : W;
  localparam int DW   = $clog2(DMAX + 2);

  gen_state_t   st;
  logic [DW-1:0] dcur;
  logic [W-1:0]  bm;
  logic [W-1:0]  xc;
  logic [W:0]    nxt;

  function automatic int popcnt(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int ctz(input logic [W-1:0] v);
    int z = 0;
    for (int i = W - 1; i >= 0; i--) if (v[i]) z = i;
    return z;
  endfunction

  function automatic logic [W-1:0] low_ones(input int k);
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = (i < k);
    return v;
  endfunction

  // Next larger value with the same number of set bits; bit W flags overflow.
  function automatic logic [W:0] next_same(input logic [W-1:0] x);
    logic [W:0] xe, c, r, t;
    xe = {1'b0, x};
    c  = xe & (~xe + (W+1)'(1));
    r  = xe + c;
    t  = (r ^ xe) >> 2;
    t  = t >> ctz(x);
    return r | t;
  endfunction

  assign nxt = next_same(bm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= G_IDLE;
      dcur <= '0;
      bm   <= '0;
      xc   <= '0;
    end else if (init) begin
      st   <= G_BROAD;
      dcur <= '0;
      bm   <= '0;
      xc   <= '0;
    end else begin
      unique case (st)
        G_BROAD: if (adv) begin
          if (dcur != '0 && !nxt[W]) begin
            bm <= nxt[W-1:0];
          end else if (int'(dcur) < DMAX) begin
            dcur <= dcur + DW'(1);
            bm   <= low_ones(int'(dcur) + 1);
          end else begin
            st <= G_SKIP;
            xc <= '0;
          end
        end
        G_SKIP: begin
          if (popcnt(xc) > MAXD) st <= G_EXH;
          else if (&xc)          st <= G_EMPTY;
          else                   xc <= xc + W'(1);
        end
        G_EXH: if (adv) begin
          if (&xc) st <= G_EMPTY;
          else begin
            xc <= xc + W'(1);
            st <= G_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  assign rdy   = (st == G_BROAD) || (st == G_EXH);
  assign empty = (st == G_EMPTY);
  assign rmask = (st == G_BROAD) ? bm : xc;

  assert_round_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == G_BROAD) |-> (popcnt(bm) == int'(dcur)));
  assert_round_rising_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == G_BROAD) && ($past(st) == G_BROAD) && $past(adv) && !$past(init)
      && (dcur == $past(dcur)) && (dcur != '0)) |-> (bm > $past(bm)));
  assert_exh_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == G_EXH) |-> (popcnt(xc) > MAXD));
endmodule

// File: rtl/puf_key_search.sv
module puf_key_search
  import puf_search_pkg::*;
#(
  parameter int W     = 16,
  parameter int NSAMP = 351,
  parameter int MAXD  = 2,
  parameter int IDXW  = (W > 1) ? $clog2(W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              samp_valid,
  output logic              samp_ready,
  input  logic [W-1:0]      samp_data,
  input  logic [W*IDXW-1:0] rank_tbl,
  output logic              cand_valid,
  input  logic              cand_ready,
  output logic [W-1:0]      cand_data,
  input  logic              chk_done,
  input  logic              chk_match,
  output logic              done,
  output logic              success,
  output logic              failure,
  output logic [W-1:0]      key,
  output logic [W:0]        cand_count
);
  localparam int CNTW = W + 1;

  ctl_state_t st, st_n;
  logic maj_clr, maj_full, mg_init, mg_adv, mg_rdy, mg_empty;
  logic [W-1:0] maj, rmask, bmask, cand_q, key_q;
  logic [CNTW-1:0] cnt_q;
  logic succ_q, fail_q;

  puf_majority #(.W(W), .NSAMP(NSAMP)) u_maj (
    .clk(clk), .rst_n(rst_n), .clr(maj_clr),
    .take(samp_valid && samp_ready), .data(samp_data),
    .maj(maj), .full(maj_full)
  );

  puf_mask_gen #(.W(W), .MAXD(MAXD)) u_gen (
    .clk(clk), .rst_n(rst_n), .init(mg_init), .adv(mg_adv),
    .rdy(mg_rdy), .empty(mg_empty), .rmask(rmask)
  );

  puf_rank_map #(.W(W), .IDXW(IDXW)) u_map (
    .rmask(rmask), .tbl(rank_tbl), .bmask(bmask)
  );

  always_comb begin
    st_n    = st;
    maj_clr = 1'b0;
    mg_init = 1'b0;
    mg_adv  = 1'b0;
    unique case (st)
      T_IDLE, T_DONE: if (start) begin
        st_n    = T_SAMPLE;
        maj_clr = 1'b1;
      end
      T_SAMPLE: if (maj_full) st_n = T_LAUNCH;
      T_LAUNCH: begin
        mg_init = 1'b1;
        st_n    = T_SEEK;
      end
      T_SEEK: begin
        if (mg_rdy)        st_n = T_OFFER;
        else if (mg_empty) st_n = T_DONE;
      end
      T_OFFER: if (cand_ready) st_n = T_WAIT;
      T_WAIT: if (chk_done) begin
        if (chk_match) st_n = T_DONE;
        else begin
          mg_adv = 1'b1;
          st_n   = T_SEEK;
        end
      end
      default: st_n = T_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      cand_q <= '0;
      key_q  <= '0;
      cnt_q  <= '0;
      succ_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st <= st_n;
      if (maj_clr) begin
        cnt_q  <= '0;
        succ_q <= 1'b0;
        fail_q <= 1'b0;
      end
      if (st == T_SEEK && mg_rdy) cand_q <= maj ^ bmask;
      if (st == T_SEEK && !mg_rdy && mg_empty) fail_q <= 1'b1;
      if (st == T_OFFER && cand_ready) cnt_q <= cnt_q + CNTW'(1);
      if (st == T_WAIT && chk_done && chk_match) begin
        succ_q <= 1'b1;
        key_q  <= cand_q;
      end
    end
  end

  assign samp_ready = (st == T_SAMPLE) && !maj_full;
  assign cand_valid = (st == T_OFFER);
  assign cand_data  = cand_q;
  assign done       = (st == T_DONE);
  assign success    = succ_q;
  assign failure    = fail_q;
  assign key        = key_q;
  assign cand_count = cnt_q;

  assert_cand_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !cand_ready) |=> (cand_valid && $stable(cand_data)));
  assert_outcome_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (success ^ failure));
  assert_quiet_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cand_valid && !samp_ready));
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cand_count <= {1'b1, {W{1'b0}}});
  assert_fail_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failure) |-> (cand_count == {1'b1, {W{1'b0}}}));
endmodule

// File: tb/tb_puf_key_search.sv
module tb_puf_key_search;
  localparam int W     = 8;
  localparam int NSAMP = 5;
  localparam int MAXD  = 2;
  localparam int IDXW  = 3;
  localparam int NCAND = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic samp_valid = 1'b0;
  logic samp_ready;
  logic [W-1:0] samp_data = '0;
  logic [W*IDXW-1:0] rank_tbl;
  logic cand_valid;
  logic cand_ready = 1'b0;
  logic [W-1:0] cand_data;
  logic chk_done = 1'b0;
  logic chk_match = 1'b0;
  logic done, success, failure;
  logic [W-1:0] key;
  logic [W:0] cand_count;

  always #2 clk = ~clk;

  puf_key_search #(.W(W), .NSAMP(NSAMP), .MAXD(MAXD), .IDXW(IDXW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .samp_valid(samp_valid), .samp_ready(samp_ready), .samp_data(samp_data),
    .rank_tbl(rank_tbl), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_data(cand_data), .chk_done(chk_done), .chk_match(chk_match),
    .done(done), .success(success), .failure(failure), .key(key),
    .cand_count(cand_count)
  );

  int checks = 0;
  int fails  = 0;
  int tbl [W];
  int order [$];
  logic [W-1:0] expmaj, target;
  bit never_match, stray_en, stray_done, run_en;
  int exp_idx, ncyc, pend_dly, cycles;
  bit pending, pend_match, seen_cur;
  bit used [NCAND];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pop(input int v);
    int n = 0;
    for (int i = 0; i < W; i++) n += (v >> i) & 1;
    return n;
  endfunction

  function automatic logic [W-1:0] to_bits(input int m);
    logic [W-1:0] b = '0;
    for (int r = 0; r < W; r++) if ((m >> r) & 1) b[tbl[r]] = 1'b1;
    return b;
  endfunction

  function automatic logic [W-1:0] exp_cand(input int k);
    return expmaj ^ to_bits(order[k]);
  endfunction

  // Per-clock reference: candidate sequence, handshake, checker responses.
  always @(negedge clk) begin
    bit rdy_now;
    ncyc++;
    chk_done  <= 1'b0;
    chk_match <= 1'b0;
    rdy_now = (ncyc % 3) != 1;
    cand_ready <= rdy_now;
    if (run_en) begin
      if (pending) chk(!cand_valid, "R6 offer while outstanding", int'(cand_valid), 0);
      if (cand_valid && !seen_cur) begin
        seen_cur = 1'b1;
        chk(exp_idx < NCAND, "R5 too many candidates", exp_idx, NCAND);
        if (exp_idx < NCAND)
          chk(cand_data == exp_cand(exp_idx), "R2/R3/R5 candidate order",
              int'(cand_data), int'(exp_cand(exp_idx)));
        chk(!used[cand_data], "R5 repeated candidate", int'(cand_data), 0);
        used[cand_data] = 1'b1;
      end
      if (cand_valid && !rdy_now && stray_en && !stray_done && !pending) begin
        stray_done = 1'b1;
        chk_done  <= 1'b1;   // R6: not outstanding, must be ignored
        chk_match <= 1'b1;
      end else if (cand_valid && rdy_now) begin
        pending    = 1'b1;
        pend_dly   = 2;
        pend_match = (cand_data == target) && !never_match;
        exp_idx++;
        seen_cur = 1'b0;
      end else if (pending) begin
        pend_dly--;
        if (pend_dly == 0) begin
          pending = 1'b0;
          chk_done  <= 1'b1;
          chk_match <= pend_match;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_case(input string name, input logic [W-1:0] truth,
                          input logic [W-1:0] n1, input logic [W-1:0] n2,
                          input logic [W-1:0] tgt, input bit nm,
                          input bit stray, input bit poke);
    int ones [W];
    int kexp;
    bit poked;
    for (int i = 0; i < W; i++) ones[i] = 0;
    target = tgt; never_match = nm; stray_en = stray; stray_done = 1'b0;
    exp_idx = 0; pending = 1'b0; seen_cur = 1'b0;
    for (int i = 0; i < NCAND; i++) used[i] = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int s = 0; s < NSAMP; s++) begin
      logic [W-1:0] v;
      bit acc;
      v = truth ^ ((s == 1) ? n1 : '0) ^ ((s == 3) ? n2 : '0);
      for (int i = 0; i < W; i++) ones[i] += int'(v[i]);
      if (s % 2 == 1) @(negedge clk);
      samp_valid = 1'b1; samp_data = v;
      acc = samp_ready;
      while (!acc) begin @(negedge clk); acc = samp_ready; end
      @(posedge clk);
      @(negedge clk) samp_valid = 1'b0;
    end
    for (int i = 0; i < W; i++) expmaj[i] = (ones[i] > NSAMP / 2);
    run_en = 1'b1;
    poked = 1'b0;
    kexp = NCAND;
    if (!nm) for (int k = 0; k < NCAND; k++) if (exp_cand(k) == tgt && kexp == NCAND) kexp = k + 1;
    @(negedge clk);
    chk(!samp_ready, "R1 ready drops after NSAMP", int'(samp_ready), 0);
    while (!done) begin
      if (poke && !poked && exp_idx == 3) begin
        poked = 1'b1;
        start = 1'b1;                  // R9: ignored mid-run
        @(negedge clk) start = 1'b0;
      end else @(negedge clk);
    end
    run_en = 1'b0;
    chk(success == !nm, {name, " R7 success"}, int'(success), int'(!nm));
    chk(failure == nm, {name, " R8 failure"}, int'(failure), int'(nm));
    chk(int'(cand_count) == kexp, {name, " R7/R8 count"}, int'(cand_count), kexp);
    if (!nm) chk(key == tgt, {name, " R7 key"}, int'(key), int'(tgt));
    chk(!samp_ready && !cand_valid, {name, " R9 quiet when done"},
        int'({samp_ready, cand_valid}), 0);
  endtask

  initial begin
    for (int r = 0; r < W; r++) begin
      tbl[r] = (3 * r + 5) % W;        // R4: entry r = r-th most error-prone bit
      rank_tbl[r*IDXW +: IDXW] = IDXW'(tbl[r]);
    end
    for (int d = 0; d <= MAXD; d++)
      for (int m = 0; m < NCAND; m++) if (pop(m) == d) order.push_back(m);
    for (int m = 0; m < NCAND; m++) if (pop(m) > MAXD) order.push_back(m);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !success && !failure && !cand_valid && !samp_ready && cand_count == 0,
        "R9 reset state", int'({done, success, failure, cand_valid, samp_ready}), 0);
    // R2: clean readings, unmodified value accepted first
    run_case("A", 8'hA5, 8'h00, 8'h00, 8'hA5, 1'b0, 1'b0, 1'b0);
    // R1 R3 R4: noisy minority readings, one flip of rank entry 2
    run_case("B", 8'h3C, 8'hFF, 8'h0F, 8'h3C ^ (8'h1 << tbl[2]), 1'b0, 1'b0, 1'b0);
    // R3 R6 R9: two flips, stray verdict, start poked mid-run
    run_case("C", 8'h5A, 8'hC3, 8'h81, 8'h5A ^ (8'h1 << tbl[1]) ^ (8'h1 << tbl[4]),
             1'b0, 1'b1, 1'b1);
    // R5: four flips, reached only in the exhaustive phase
    run_case("D", 8'h96, 8'h11, 8'h22, 8'h96 ^ (8'h1 << tbl[0]) ^ (8'h1 << tbl[2])
             ^ (8'h1 << tbl[5]) ^ (8'h1 << tbl[7]), 1'b0, 1'b0, 1'b0);
    // R5 R8: nothing accepted, full space offered once each
    run_case("E", 8'h0F, 8'hF0, 8'h3C, 8'h00, 1'b1, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule